// File: doc/BRIEF.md
# Auto-Negotiation Restart Sequencer

This block decides when a PHY's auto-negotiation runs, when it is forced quiet, and when it starts again. It watches the negotiation enable bit and the self-clearing restart bit of the basic control register, the receive link status and a negotiation-done indication from the arbitration logic. From these it drives a transmit/link-pulse inhibit and a one-cycle strobe that tells the pulse generator to begin sending fast link pulse bursts. It also reports its state.

A management restart does not go straight back into negotiation. The block first holds the line silent for a long break-link interval, so that the link partner drops its link. Only then does it start bursting again. If an established link fails on its own, the partner is already down, so negotiation resumes at once. A device strapped to come up in forced-technology mode starts negotiating only after software has written the enable bit low and then high again.

The break-link interval is a clock count parameter. The default is about 1.5 s at a 25 MHz clock.

Top module: `aneg_restart_seq`

## Requirements
- R1: While reset is asserted and just after its release, `state_o` is 2'b00, and `tx_inhibit`, `flp_start` and `restart_bit` are 0.
- R2: `state_o` uses this encoding: 2'b00 disabled, 2'b01 break-link, 2'b10 negotiating, 2'b11 complete. If `strap_an_en` is 1 and `an_enable` is 1, the sequencer is negotiating in the second cycle after reset release, with `flp_start` high for that cycle only.
- R3: If `strap_an_en` is 0 during reset release, the sequencer stays disabled while `an_enable` stays 1. It starts negotiating, with a `flp_start` pulse, in the cycle after `an_enable` returns to 1 following at least one cycle at 0.
- R4: While negotiating, a high `an_done` moves the state to complete on the next cycle.
- R5: A one-cycle `restart_set` pulse makes `restart_bit` read 1 in the next cycle. In the cycle after that, `restart_bit` reads 0, and if the state was negotiating or complete, the state is break-link.
- R6: Break-link lasts exactly BREAK_CYCLES cycles. `tx_inhibit` is 1 in exactly the break-link cycles.
- R7: When the break-link interval ends, the state goes to negotiating with `flp_start` high for one cycle.
- R8: A restart accepted during break-link restarts the full interval, so the state stays break-link for BREAK_CYCLES cycles after the reload.
- R9: In complete, a low `link_ok` with no pending restart returns the state to negotiating with a `flp_start` pulse and no break-link interval.
- R10: A low `an_enable` puts the state in disabled on the next cycle from any state, with `tx_inhibit` released. A restart that arrives while disabled is discarded, and the state stays disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronised to clk |
| strap_an_en | input | 1 | Power-up mode: 1 negotiate, 0 forced technology; sampled once after reset |
| an_enable | input | 1 | Negotiation enable bit level |
| restart_set | input | 1 | Write of 1 to the restart bit |
| link_ok | input | 1 | Receive link is valid |
| an_done | input | 1 | Arbitration reports negotiation complete |
| tx_inhibit | output | 1 | Suppress transmit data and link pulses |
| flp_start | output | 1 | One-cycle strobe to begin FLP bursts |
| restart_bit | output | 1 | Read value of the self-clearing restart bit |
| state_o | output | 2 | Sequencer state, encoded as in R2 |

## Verification
The bench builds the sequencer with BREAK_CYCLES set to 8, so the whole break-link interval fits inside a short vector table. With that value, the bench can count the interval cycle by cycle, both for a single restart and for a reload part-way through. The forced-strap path and the discarded restart while disabled need a second reset with the strap low, and directed steps cover both.

// File: rtl/aneg_pkg.sv
package aneg_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'b00,
    ST_BREAK = 2'b01,
    ST_NEG   = 2'b10,
    ST_DONE  = 2'b11
  } an_state_t;
endpackage

// File: rtl/aneg_enable_gate.sv
// Arms the sequencer. Armed at once if the strap selects negotiation;
// otherwise armed only after the enable bit has been seen low.
module aneg_enable_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_an_en,
  input  logic an_enable,
  output logic armed
);
  logic init_q;
  logic armed_q;
  logic init_d;
  logic armed_d;

  always_comb begin
    init_d  = 1'b1;
    armed_d = armed_q;
    if (!init_q)
      armed_d = strap_an_en | ~an_enable;
    else if (!an_enable)
      armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      init_q  <= init_d;
      armed_q <= armed_d;
    end
  end

  assign armed = armed_q & init_q;
endmodule

// File: rtl/aneg_restart_latch.sv
// Self-clearing restart bit: set by a write, cleared when consumed.
module aneg_restart_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic consume_i,
  output logic pend_o
);
  logic pend_q;
  logic pend_d;

  always_comb begin
    pend_d = pend_q;
    if (consume_i) pend_d = 1'b0;
    if (set_i)     pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/aneg_break_timer.sv
// Down-counter for the break-link interval.
module aneg_break_timer #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic zero_o
);
  localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | (run_i & (cnt_q != '0));
    cnt_d  = load_i ? LOAD_VAL : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/aneg_restart_seq.sv
module aneg_restart_seq #(
  parameter int unsigned BREAK_CYCLES = 37_500_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_an_en,
  input  logic       an_enable,
  input  logic       restart_set,
  input  logic       link_ok,
  input  logic       an_done,
  output logic       tx_inhibit,
  output logic       flp_start,
  output logic       restart_bit,
  output logic [1:0] state_o
);
  import aneg_pkg::*;

  an_state_t st_q, st_d;
  logic      flp_q, flp_d;
  logic      armed;
  logic      pend;
  logic      tmr_load;
  logic      tmr_zero;

  aneg_enable_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_an_en (strap_an_en),
    .an_enable   (an_enable),
    .armed       (armed)
  );

  // Every pending request is consumed the cycle after it is seen:
  // accepted when active, discarded when disabled.
  aneg_restart_latch u_rst_bit (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (restart_set),
    .consume_i (pend),
    .pend_o    (pend)
  );

  aneg_break_timer #(.CYCLES(BREAK_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .run_i  (st_q == ST_BREAK),
    .zero_o (tmr_zero)
  );

  always_comb begin
    st_d     = st_q;
    flp_d    = 1'b0;
    tmr_load = 1'b0;
    case (st_q)
      ST_OFF: begin
        if (armed) begin
          st_d  = ST_NEG;
          flp_d = 1'b1;
        end
      end
      ST_NEG: begin
        if (pend) begin
          st_d     = ST_BREAK;
          tmr_load = 1'b1;
        end else if (an_done) begin
          st_d = ST_DONE;
        end
      end
      ST_DONE: begin
        if (pend) begin
          st_d     = ST_BREAK;
          tmr_load = 1'b1;
        end else if (!link_ok) begin
          st_d  = ST_NEG;
          flp_d = 1'b1;
        end
      end
      ST_BREAK: begin
        if (pend) begin
          tmr_load = 1'b1;
        end else if (tmr_zero) begin
          st_d  = ST_NEG;
          flp_d = 1'b1;
        end
      end
      default: st_d = ST_OFF;
    endcase
    if (!an_enable) begin
      st_d     = ST_OFF;
      flp_d    = 1'b0;
      tmr_load = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OFF;
      flp_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      flp_q <= flp_d;
    end
  end

  assign tx_inhibit  = (st_q == ST_BREAK);
  assign flp_start   = flp_q;
  assign restart_bit = pend;
  assign state_o     = st_q;
endmodule

// File: rtl/aneg_restart_seq_chk.sv
module aneg_restart_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       an_enable,
  input logic       link_ok,
  input logic       tx_inhibit,
  input logic       flp_start,
  input logic       restart_bit,
  input logic [1:0] state_o
);
  // R1 / R2: a burst strobe only ever comes with the negotiating state
  assert_flp_in_neg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flp_start |-> state_o == 2'b10);

  // R7: the strobe lasts a single cycle
  assert_flp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flp_start |=> !flp_start);

  // R5: break-link is only entered from an accepted restart
  assert_break_from_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b01 && $past(state_o) != 2'b01) |-> $past(restart_bit));

  // R7: leaving break-link into negotiation always issues the strobe
  assert_break_exit_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == 2'b01 && state_o == 2'b10) |-> flp_start);

  // R9: link loss in complete resumes negotiation directly
  assert_link_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b11 && !link_ok && an_enable && !restart_bit)
      |=> (state_o == 2'b10 && flp_start));

  // R10: a low enable forces disabled and releases the inhibit
  assert_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !an_enable |=> (state_o == 2'b00 && !tx_inhibit));
endmodule

bind aneg_restart_seq aneg_restart_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .an_enable   (an_enable),
  .link_ok     (link_ok),
  .tx_inhibit  (tx_inhibit),
  .flp_start   (flp_start),
  .restart_bit (restart_bit),
  .state_o     (state_o)
);

// File: tb/aneg_restart_seq_tb.sv
module aneg_restart_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BRK = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       strap_an_en;
  logic       an_enable;
  logic       restart_set;
  logic       link_ok;
  logic       an_done;
  logic       tx_inhibit;
  logic       flp_start;
  logic       restart_bit;
  logic [1:0] state_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aneg_restart_seq #(.BREAK_CYCLES(BRK)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_an_en (strap_an_en),
    .an_enable   (an_enable),
    .restart_set (restart_set),
    .link_ok     (link_ok),
    .an_done     (an_done),
    .tx_inhibit  (tx_inhibit),
    .flp_start   (flp_start),
    .restart_bit (restart_bit),
    .state_o     (state_o)
  );

  // {en, restart, link, done, state[1:0], inhibit, flp}
  localparam int NV = 21;
  localparam logic [7:0] VEC [NV] = '{
    8'b1000_00_0_0, // R2 arming cycle
    8'b1000_10_0_1, // R2 start with strobe
    8'b1000_10_0_0, // R7 strobe gone
    8'b1011_11_0_0, // R4 complete
    8'b1010_11_0_0,
    8'b1110_11_0_0, // R5 request latched
    8'b1010_01_1_0, // R5 accepted, R6 cycle 1
    8'b1010_01_1_0,
    8'b1010_01_1_0,
    8'b1010_01_1_0,
    8'b1010_01_1_0,
    8'b1010_01_1_0,
    8'b1010_01_1_0,
    8'b1010_01_1_0, // R6 cycle 8
    8'b1010_10_0_1, // R7 expiry strobe
    8'b1000_10_0_0,
    8'b1011_11_0_0, // R4
    8'b1000_10_0_1, // R9 link loss
    8'b1011_11_0_0,
    8'b0000_00_0_0, // R10 disable
    8'b1000_10_0_1  // R3 re-enable after low
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic rs, input logic lk, input logic dn);
    an_enable   = en;
    restart_set = rs;
    link_ok     = lk;
    an_done     = dn;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic strap);
    rst_n       = 1'b0;
    strap_an_en = strap;
    an_enable   = 1'b1;
    restart_set = 1'b0;
    link_ok     = 1'b0;
    an_done     = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 state in reset", state_o, 0);
    check("R1 inhibit in reset", tx_inhibit, 0);
    check("R1 strobe in reset", flp_start, 0);
    check("R1 restart bit in reset", restart_bit, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R6 act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    do_reset(1'b1);
    check("R1 state after release", state_o, 0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
      check($sformatf("R2/R4-R10 vec%0d state", i), state_o, VEC[i][3:2]);
      check($sformatf("R6 vec%0d inhibit", i), tx_inhibit, VEC[i][1]);
      check($sformatf("R7 vec%0d strobe", i), flp_start, VEC[i][0]);
    end

    // R5: restart from negotiating, self-clearing bit
    step(1, 1, 0, 0);
    check("R5 bit set", restart_bit, 1);
    check("R5 still negotiating", state_o, 2);
    step(1, 0, 0, 0);
    check("R5 bit cleared", restart_bit, 0);
    check("R5 break-link entered", state_o, 1);
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    // R8: reload part-way through break-link
    step(1, 1, 0, 0);
    cnt = 0;
    while (state_o == 2'b01 && cnt < 40) begin
      cnt++;
      step(1, 0, 0, 0);
    end
    check("R8 break-link samples after reload request", cnt, BRK + 1);
    check("R7 strobe after reload expiry", flp_start, 1);

    // R10: disable during break-link releases inhibit
    step(1, 1, 0, 0);
    step(1, 0, 0, 0);
    check("R10 in break-link before disable", tx_inhibit, 1);
    step(0, 0, 0, 0);
    check("R10 state disabled", state_o, 0);
    check("R10 inhibit released", tx_inhibit, 0);
    // R10: restart while disabled is discarded
    step(0, 1, 0, 0);
    check("R10 bit visible while disabled", restart_bit, 1);
    step(0, 0, 0, 0);
    check("R10 bit discarded", restart_bit, 0);
    check("R10 stays disabled", state_o, 0);
    check("R10 no inhibit", tx_inhibit, 0);

    // R3: forced-technology power-up
    do_reset(1'b0);
    for (int k = 0; k < 4; k++) begin
      step(1, 0, 0, 0);
      check("R3 forced stays disabled", state_o, 0);
    end
    step(1, 1, 0, 0);
    step(1, 0, 0, 0);
    check("R3 restart ignored when forced", state_o, 0);
    check("R3 no inhibit when forced", tx_inhibit, 0);
    step(0, 0, 0, 0);
    check("R3 enable low", state_o, 0);
    step(1, 0, 0, 0);
    check("R3 start after clear-then-set", state_o, 2);
    check("R3 strobe after clear-then-set", flp_start, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule